// File: doc/BRIEF.md
# Two-Mode Event Timer

This block is a bus-attached event timer with a 64-bit terminal count. Software writes the terminal count as two 32-bit words and then writes a control word. The control word starts the counter, picks the mode and gates the interrupt line. The counter moves forward only on cycles where the timer tick input is high. When the counter reaches the terminal count, the block sets a pending flag.

There are two modes. In periodic mode the counter returns to zero at each expiry, so expiries repeat at a fixed spacing. In single-count mode the counter stops at the first expiry and stays there until software starts it again. The pending flag is cleared by writing a one to it. The interrupt output is a level signal: it is high while the flag is set and the interrupt is unmasked.

To program the block, software disables it, writes both count words, and then writes the control word with the enable bit set. Any control write that has the enable bit set restarts the count from zero.

Top module: `evt_timer`

## Requirements
- R1: Registers by byte offset: 0x00 holds the low count word and 0x04 the high count word, both read back as written. 0x10 holds the control bits [2:0] and reads back with zeros above them. 0x18 holds the pending flag in bit 0.
- R2: A read from any offset other than 0x00, 0x04, 0x10 or 0x18 returns zero.
- R3: A control write with bit 0 set restarts the counter from zero and re-arms a halted single-count run. After such a write, a terminal count of N expires on the (N+1)-th tick.
- R4: The counter advances only on cycles where tick is high and control bit 0 is set. Tick-free cycles and a disabled timer (control written with bit 0 clear) produce no expiry.
- R5: When control bit 1 is 0 (periodic mode), the counter returns to zero at expiry, so a terminal count of N expires every N+1 ticks.
- R6: When control bit 1 is 1 (single-count mode), the counter stops at expiry. No further expiry happens until the next enabling control write.
- R7: Writing 1 to bit 0 of offset 0x18 clears the pending flag. Writing 0 leaves it unchanged.
- R8: If an expiry and a clearing write fall in the same cycle, the flag stays set.
- R9: irq is high exactly when the pending flag is set and control bit 2 is 1. When bit 2 is 0, an expiry still sets the flag but irq stays low.
- R10: The terminal count is the full {high word, low word}. A nonzero high word prevents expiry at the low-word value.
- R11: After reset, every register reads zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable strobe, one count per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt, active high |

## Verification
The bench builds the block with its default 64-bit count width and 5-bit offset. It sweeps terminal counts 0 through 5 in both modes, so every expiry in several periods and every hold after a single count is checked tick by tick against arithmetic in the bench. One run uses a nonzero high word to show that the upper word takes part in the compare. All 8 word offsets are read, which covers both the mapped and the unmapped ones.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_LO   = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_HI   = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(5'h18);

  logic [31:0]      load_lo, load_hi;
  logic [2:0]       ctrl_q;
  logic             status_q;
  logic             halt_q;
  logic [CNT_W-1:0] cnt_q;

  wire [63:0]      load_full = {load_hi, load_lo};
  wire [CNT_W-1:0] load_val  = load_full[CNT_W-1:0];
  wire wr_ctrl  = bus_wr && bus_addr == OFS_CTRL;
  wire wr_stat  = bus_wr && bus_addr == OFS_STAT;
  wire running  = ctrl_q[0] && !halt_q;
  wire hit      = running && tick && cnt_q == load_val;

  assign irq = status_q & ctrl_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_lo <= '0;
      load_hi <= '0;
      ctrl_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_LO) load_lo <= bus_wdata;
      if (bus_addr == OFS_HI) load_hi <= bus_wdata;
      if (wr_ctrl)            ctrl_q  <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (wr_ctrl && bus_wdata[0]) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (hit) begin
      if (ctrl_q[1]) halt_q <= 1'b1;
      else           cnt_q  <= '0;
    end else if (running && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       status_q <= 1'b0;
    else if (hit)                     status_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) status_q <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      OFS_LO:   bus_rdata = load_lo;
      OFS_HI:   bus_rdata = load_hi;
      OFS_CTRL: bus_rdata = {29'd0, ctrl_q};
      OFS_STAT: bus_rdata = {31'd0, status_q};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int CNT_W  = 64,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wbit0,
  input logic              irq,
  input logic              status_q,
  input logic [2:0]        ctrl_q,
  input logic [CNT_W-1:0]  cnt_q
);
  wire wr_ctrl = bus_wr && bus_addr == ADDR_W'(5'h10);
  wire wr_stat = bus_wr && bus_addr == ADDR_W'(5'h18);

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wbit0 |=> cnt_q == '0);

  // R4
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !wr_ctrl |=> $stable(cnt_q) && !$rose(status_q));

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] && !wr_ctrl |=> $stable(cnt_q));

  // R6
  oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] && status_q && !wr_ctrl |=> $stable(cnt_q));

  // R7
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && wbit0 && !tick |=> !status_q);

  // R9
  masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[2] |-> !irq);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status_q);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wbit0(bus_wdata[0]), .irq(irq), .status_q(status_q), .ctrl_q(ctrl_q),
  .cnt_q(cnt_q)
);

// File: tb/sim_evt_timer.sv
`timescale 1ns/1ps
module sim_evt_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  evt_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic tk();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic arm(input logic [31:0] n, input logic [31:0] hi, input logic [2:0] c);
    wr(5'h10, 32'd0); wr(5'h00, n); wr(5'h04, hi); wr(5'h10, {29'd0, c});
  endtask

  task automatic flag(input string req, input logic e);
    logic [31:0] d;
    rd(5'h18, d);
    chk(req, d, {31'd0, e});
    chk(req, {31'd0, irq}, {31'd0, e});
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 / R2
    for (int a = 0; a < 32; a += 4) begin
      rd(a[4:0], d); chk("R11", d, 32'd0);
    end
    chk("R11", {31'd0, irq}, 32'd0);
    // R1 / R2
    wr(5'h00, 32'hA5A5_1234); wr(5'h04, 32'h0F0F_5678); wr(5'h10, 32'hFFFF_FFF6);
    rd(5'h00, d); chk("R1", d, 32'hA5A5_1234);
    rd(5'h04, d); chk("R1", d, 32'h0F0F_5678);
    rd(5'h10, d); chk("R1", d, 32'h6);
    for (int a = 8; a < 32; a += 4) begin
      if (a != 16 && a != 24) begin
        wr(a[4:0], 32'hFFFF_FFFF); rd(a[4:0], d); chk("R2", d, 32'd0);
      end
    end
    // R5: periodic sweep
    for (int n = 0; n < 6; n++) begin
      arm(n, 0, 3'b101);
      for (int k = 1; k <= 3 * (n + 1); k++) begin
        tk();
        flag("R5", (k % (n + 1)) == 0);
        if ((k % (n + 1)) == 0) wr(5'h18, 32'd1);
      end
    end
    // R6 / R3: single-count sweep
    for (int n = 0; n < 6; n++) begin
      arm(n, 0, 3'b111);
      for (int k = 1; k <= n + 1; k++) begin tk(); flag("R6", k == n + 1); end
      wr(5'h18, 32'd0); flag("R7", 1'b1);
      wr(5'h18, 32'd1); flag("R7", 1'b0);
      for (int k = 0; k < 3 * (n + 1); k++) tk();
      flag("R6", 1'b0);
      wr(5'h10, 32'd7);
      for (int k = 1; k <= n + 1; k++) begin tk(); flag("R3", k == n + 1); end
      wr(5'h18, 32'd1);
    end
    // R4: idle cycles and disabled timer
    arm(2, 0, 3'b101);
    tk(); tk();
    repeat (10) @(negedge clk);
    flag("R4", 1'b0);
    wr(5'h10, 32'd4);
    repeat (5) tk();
    flag("R4", 1'b0);
    // R9: masked expiry sets flag, irq low; unmasking raises irq
    arm(1, 0, 3'b001);
    tk(); tk();
    rd(5'h18, d); chk("R9", d, 32'd1); chk("R9", {31'd0, irq}, 32'd0);
    wr(5'h10, 32'd4);
    chk("R9", {31'd0, irq}, 32'd1);
    wr(5'h18, 32'd1);
    // R8: expiry and clear in same cycle
    arm(1, 0, 3'b101);
    tk(); tk(); tk();
    @(negedge clk); tick = 1'b1; bus_wr = 1'b1; bus_addr = 5'h18; bus_wdata = 32'd1;
    @(negedge clk); tick = 1'b0; bus_wr = 1'b0;
    flag("R8", 1'b1);
    wr(5'h18, 32'd1);
    // R10: high word participates
    arm(2, 1, 3'b101);
    repeat (10) tk();
    flag("R10", 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule